// File: doc/BRIEF.md
# Log-Stepped LED Brightness PWM

This block turns a 4-bit brightness code for one LED colour channel into two controls. The first is a 2-bit current sub-range select, which steers an analog current source that lies outside this block. The second is a PWM enable waveform. In the logarithmic mode each code step raises perceived brightness by about half an octave (roughly 3 dB). This works because the code is split between a coarse current range and a fine duty cycle. A linear mode serves the main and sub display channels. In that mode the duty is simply code/15 at full current.

The PWM period is 256 steps of an external period tick. A free-running counter advances once per tick. The code and the mode are both sampled only at the moment that counter wraps. A code change therefore never cuts a pulse short or stretches one within a period. In a host design, each colour channel gets one instance, and its code comes from a nibble of a serial command word: red is the upper nibble of the first data byte, green the lower nibble and blue the upper nibble of the second byte, and main and sub are the upper and lower nibbles of the third byte.

Top module: `led_bright_pwm`

## Requirements
- R1: While reset is held and directly after it, `range_o` is 2'b00 and `pwm_on_o` is 0.
- R2: An active code of 0, in either mode, gives `range_o` = 2'b00 and no `pwm_on_o` pulse during the whole period.
- R3: In logarithmic mode (`lin_mode_i` = 0), codes 1..11 select `range_o` = 2'b01 (quarter), codes 12..13 select 2'b10 (half) and codes 14..15 select 2'b11 (full).
- R4: In logarithmic mode, codes 1..11 hold `pwm_on_o` high for the first T ticks of each 256-tick period (counter values 0..T-1), where T is 8, 11, 16, 23, 32, 45, 64, 91, 128, 181 and 256 respectively.
- R5: In logarithmic mode, codes 12 and 14 give T = 181, and codes 13 and 15 give T = 256, which means the output is on for the whole period.
- R6: In linear mode (`lin_mode_i` = 1), a code n from 1 to 15 gives `range_o` = 2'b11 and T = floor((256·n + 7)/15). For example, n = 1 gives 17, n = 7 gives 119, n = 14 gives 239 and n = 15 gives 256.
- R7: The code and the mode are sampled only at the tick on which the counter wraps from 255 to 0. Changes at any other time have no effect on the period in progress, and `range_o` stays constant through a period.
- R8: The period counter advances only on cycles with `period_tick_i` = 1. While no tick arrives, `pwm_on_o` and `range_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_i | input | 4 | Brightness code, 0 = off |
| lin_mode_i | input | 1 | 1 = linear 15-step mode, 0 = logarithmic mode |
| period_tick_i | input | 1 | Advances the PWM counter by one step |
| range_o | output | 2 | Current sub-range: 00 off, 01 quarter, 10 half, 11 full |
| pwm_on_o | output | 1 | PWM enable for the current source |

## Verification
The hardest situation to reach is a code change that lands inside a running period, because the ports give no direct view of the wrap point. The stimulus keeps its own copy of the tick count, which is reset together with the design. It uses that copy to place code changes at chosen counter values. To test that mid-period changes are ignored, it loads a code well before a wrap and then disturbs both the code and the mode just after the wrap. The measured pulse width must still match the earlier code. To test the tick-hold behaviour, it stops the tick in the middle of a period and watches that both outputs stay frozen.

// File: rtl/led_pwm_pkg.sv
`timescale 1ns/1ps
package led_pwm_pkg;
    localparam int PWM_W     = 8;
    localparam int CODE_W    = 4;
    localparam int THR_W     = PWM_W + 1;
    localparam int PERIOD    = 1 << PWM_W;
    localparam int LIN_STEPS = (1 << CODE_W) - 1;

    typedef enum logic [1:0] {
        RNG_OFF  = 2'b00,
        RNG_QTR  = 2'b01,
        RNG_HALF = 2'b10,
        RNG_FULL = 2'b11
    } rng_e;

    typedef struct packed {
        rng_e             rng;
        logic [THR_W-1:0] thr;
    } drive_t;

    localparam drive_t DRIVE_OFF = '{rng: RNG_OFF, thr: '0};

    // thresholds are tuned for a 256-step period and rescaled to PERIOD
    function automatic logic [THR_W-1:0] scale256(int unsigned base);
        return THR_W'((base * PERIOD) / 256);
    endfunction

    function automatic logic [THR_W-1:0] log_thr(logic [CODE_W-1:0] c);
        case (c)
            4'd1:                 return scale256(8);
            4'd2:                 return scale256(11);
            4'd3:                 return scale256(16);
            4'd4:                 return scale256(23);
            4'd5:                 return scale256(32);
            4'd6:                 return scale256(45);
            4'd7:                 return scale256(64);
            4'd8:                 return scale256(91);
            4'd9:                 return scale256(128);
            4'd10, 4'd12, 4'd14:  return scale256(181);
            4'd11, 4'd13, 4'd15:  return scale256(256);
            default:              return '0;
        endcase
    endfunction

    function automatic rng_e log_rng(logic [CODE_W-1:0] c);
        if (c == '0)       return RNG_OFF;
        else if (c <= 11)  return RNG_QTR;
        else if (c <= 13)  return RNG_HALF;
        else               return RNG_FULL;
    endfunction

    function automatic logic [THR_W-1:0] lin_thr(logic [CODE_W-1:0] c);
        int unsigned n;
        n = 32'(c);
        return THR_W'((n * PERIOD + LIN_STEPS / 2) / LIN_STEPS);
    endfunction
endpackage

// File: rtl/led_pwm_timer.sv
`timescale 1ns/1ps
module led_pwm_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt_o <= '0;
        else if (tick_i)
            cnt_o <= cnt_o + 1'b1;
    end

    assign wrap_o = tick_i && (cnt_o == {W{1'b1}});
endmodule

// File: rtl/led_code_map.sv
`timescale 1ns/1ps
module led_code_map
    import led_pwm_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    input  logic              lin_i,
    output drive_t            drive_o
);
    always_comb begin
        drive_o = DRIVE_OFF;
        if (code_i != '0) begin
            if (lin_i) begin
                drive_o.rng = RNG_FULL;
                drive_o.thr = lin_thr(code_i);
            end else begin
                drive_o.rng = log_rng(code_i);
                drive_o.thr = log_thr(code_i);
            end
        end
    end
endmodule

// File: rtl/led_pwm_out.sv
`timescale 1ns/1ps
module led_pwm_out
    import led_pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  drive_t           next_i,
    input  logic [PWM_W-1:0] cnt_i,
    output rng_e             range_o,
    output logic             pwm_on_o
);
    drive_t act_q;

    // setting only moves at a period boundary, so a pulse is never clipped
    always_ff @(posedge clk) begin
        if (rst)
            act_q <= DRIVE_OFF;
        else if (load_i)
            act_q <= next_i;
    end

    assign range_o  = act_q.rng;
    assign pwm_on_o = ({1'b0, cnt_i} < act_q.thr);
endmodule

// File: rtl/led_bright_pwm.sv
`timescale 1ns/1ps
module led_bright_pwm
    import led_pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_i,
    input  logic              lin_mode_i,
    input  logic              period_tick_i,
    output logic [1:0]        range_o,
    output logic              pwm_on_o
);
    logic [PWM_W-1:0] cnt_q;
    logic             wrap_w;
    drive_t           next_w;
    rng_e             rng_w;

    led_pwm_timer #(.W(PWM_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .tick_i (period_tick_i),
        .cnt_o  (cnt_q),
        .wrap_o (wrap_w)
    );

    led_code_map u_map (
        .code_i  (code_i),
        .lin_i   (lin_mode_i),
        .drive_o (next_w)
    );

    led_pwm_out u_out (
        .clk      (clk),
        .rst      (rst),
        .load_i   (wrap_w),
        .next_i   (next_w),
        .cnt_i    (cnt_q),
        .range_o  (rng_w),
        .pwm_on_o (pwm_on_o)
    );

    assign range_o = rng_w;
endmodule

// File: rtl/led_pwm_chk.sv
`timescale 1ns/1ps
module led_pwm_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         tick,
    input logic [W-1:0] cnt,
    input logic [1:0]   range_o,
    input logic         pwm_on
);
    AST_OFF_DARK: assert property (@(posedge clk) disable iff (rst)
        (range_o == 2'b00) |-> !pwm_on); // R2

    AST_LEAD_HIGH: assert property (@(posedge clk) disable iff (rst)
        (range_o != 2'b00 && cnt == '0) |-> pwm_on); // R4

    AST_RANGE_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        !$stable(range_o) |-> $past(tick && cnt == {W{1'b1}})); // R7

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        !$past(tick) |-> ($stable(pwm_on) && $stable(range_o))); // R8
endmodule

bind led_bright_pwm led_pwm_chk #(.W(led_pwm_pkg::PWM_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (period_tick_i),
    .cnt     (cnt_q),
    .range_o (range_o),
    .pwm_on  (pwm_on_o)
);

// File: tb/led_bright_pwm_bench.sv
`timescale 1ns/1ps
module led_bright_pwm_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        int    rng;
        int    ones;
        string rtag;
        string dtag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] code_i = 4'd0;
    logic       lin_mode_i = 1'b0;
    logic       tick_en = 1'b0;
    logic [1:0] range_o;
    logic       pwm_on_o;

    int   n_tests = 0;
    int   n_fail  = 0;
    int   k = 0;
    int   ones = 0;
    logic [1:0] rng0 = 2'b00;
    bit   rng_ok = 1'b1;
    bit   done = 1'b0;
    exp_t sb[$];
    exp_t e;

    led_bright_pwm u_led_bright_pwm (
        .clk           (clk),
        .rst           (rst),
        .code_i        (code_i),
        .lin_mode_i    (lin_mode_i),
        .period_tick_i (tick_en),
        .range_o       (range_o),
        .pwm_on_o      (pwm_on_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int exp_thr(int c, bit lin);
        if (c == 0) return 0;
        if (lin)    return (c * 256 + 7) / 15;
        case (c)
            1: return 8;    2: return 11;   3: return 16;  4: return 23;
            5: return 32;   6: return 45;   7: return 64;  8: return 91;
            9: return 128;  10: return 181; 11: return 256;
            12: return 181; 13: return 256; 14: return 181;
            default: return 256;
        endcase
    endfunction

    function automatic int exp_rng(int c, bit lin);
        if (c == 0)  return 0;
        if (lin)     return 3;
        if (c <= 11) return 1;
        if (c <= 13) return 2;
        return 3;
    endfunction

    // mirror of the tick count, reset along with the design
    always @(posedge clk) begin
        if (rst)          k <= 0;
        else if (tick_en) k <= (k == 255) ? 0 : k + 1;
    end

    // monitor: measure each period and compare with the scoreboard
    always @(negedge clk) begin
        if (!rst && tick_en) begin
            if (k == 0) begin
                rng0   = range_o;
                rng_ok = 1'b1;
                ones   = 0;
            end else if (range_o != rng0) begin
                rng_ok = 1'b0;
            end
            if (pwm_on_o) ones++;
            if (k == 255 && sb.size() > 0) begin
                e = sb.pop_front();
                chk(rng_ok, "R7", "range steady in period", int'(rng_ok), 1);
                chk(int'(rng0) == e.rng, e.rtag, "range", int'(rng0), e.rng);
                chk(ones == e.ones, e.dtag, "on ticks", ones, e.ones);
            end
        end
    end

    task automatic wait_k(int target);
        do begin
            @(posedge clk); #1;
        end while (k != target);
    endtask

    // driver: load a code before the wrap and queue what the next period must show
    task automatic play(int c, bit lin, string rtag, string dtag, bit disturb, bit pause);
        logic [1:0] r_hold;
        logic       p_hold;
        bit         frozen;
        wait_k(200);
        code_i     = 4'(c);
        lin_mode_i = lin;
        sb.push_back('{rng: exp_rng(c, lin), ones: exp_thr(c, lin), rtag: rtag, dtag: dtag});
        wait_k(0);
        if (disturb) begin
            wait_k(10);
            code_i     = ~4'(c);   // R7: must not reach this period
            lin_mode_i = !lin;
        end
        if (pause) begin
            wait_k(100);
            tick_en = 1'b0;
            r_hold  = range_o;
            p_hold  = pwm_on_o;
            frozen  = 1'b1;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (range_o != r_hold || pwm_on_o != p_hold) frozen = 1'b0;
            end
            chk(frozen, "R8", "outputs held without tick", int'(frozen), 1);
            @(posedge clk); #1;
            tick_en = 1'b1;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(range_o == 2'b00, "R1", "range in reset", int'(range_o), 0);
        chk(pwm_on_o == 1'b0, "R1", "pwm in reset", int'(pwm_on_o), 0);
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        chk(range_o == 2'b00 && pwm_on_o == 1'b0, "R1", "after reset",
            int'({range_o, pwm_on_o}), 0);
        // first period runs with the reset setting: off (R2)
        sb.push_back('{rng: 0, ones: 0, rtag: "R2", dtag: "R2"});
        @(posedge clk); #1;
        tick_en = 1'b1;

        // R3 / R4 / R5: every logarithmic code
        for (int c = 1; c < 16; c++)
            play(c, 1'b0, "R3", (c <= 11) ? "R4" : "R5", 1'b0, 1'b0);
        play(0, 1'b0, "R2", "R2", 1'b0, 1'b0);
        // R6: linear mode
        play(1, 1'b1, "R6", "R6", 1'b0, 1'b0);
        play(7, 1'b1, "R6", "R6", 1'b0, 1'b0);
        play(14, 1'b1, "R6", "R6", 1'b0, 1'b0);
        play(15, 1'b1, "R6", "R6", 1'b0, 1'b0);
        play(0, 1'b1, "R2", "R2", 1'b0, 1'b0);
        // R7: mid-period disturbance
        play(9, 1'b0, "R7", "R7", 1'b1, 1'b0);
        play(12, 1'b1, "R7", "R7", 1'b1, 1'b0);
        play(3, 1'b0, "R7", "R7", 1'b0, 1'b0);
        // R8: tick paused mid-period, width still exact
        play(10, 1'b0, "R8", "R8", 1'b0, 1'b1);
        play(5, 1'b1, "R8", "R8", 1'b0, 1'b1);

        while (sb.size() > 0) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule